// File: doc/BRIEF.md
# Pipelined Radix-4 Add-Compare-Select Unit

This block is the arithmetic core of a trellis decoder whose states are served one after another by a single shared unit. Each cycle it takes four predecessor path metrics and the four branch metrics that go with them. It forms the four candidate sums and keeps the smallest one. It returns the surviving metric and a two-bit code that identifies the predecessor it came from. The work is spread across three register stages, so a new state can enter every cycle and its result appears three cycles later.

Some states have only two real predecessors, and some slots may carry metrics that belong to the wrong frame. For these cases a per-cycle control with two bits can remove either the lower or the upper pair of candidates from the contest. Slots that the scheduler fills only to keep the loop depth matched can be marked as filler. The mark travels with the result so that the consumer can discard that result. A valid bit and a state tag travel alongside the data through every stage. Scheduling and metric storage are outside this block.

Top module: `acs4_pipe`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it rises, `outValid` and `outDummy` are 0. Results that were in flight when reset was asserted never appear at the outputs.
- R2: The unit accepts one state per cycle. The result of inputs sampled at rising edge k is visible after edge k+2, and `outValid` equals `inValid` as it was at that edge.
- R3: Candidate k is the sum of `pathIn[k*MW +: MW]` and `branchIn[k*BW +: BW]`. When the sum exceeds 2^MW-1 it is held at 2^MW-1. `outMetric` is the smallest of the four candidates.
- R4: `outDecision` holds the index (0 to 3) of the candidate that supplied `outMetric`. When candidates are equal, the lowest index wins.
- R5: `halfOff[0]` forces candidates 0 and 1 to 2^MW-1, and `halfOff[1]` does the same to candidates 2 and 3. A suppressed candidate can win only if every candidate that is not suppressed also equals 2^MW-1. With both bits set, the result is metric 2^MW-1 and decision 0.
- R6: `outTag` repeats the `inTag` of the same slot, with the same latency as the data.
- R7: `outDummy` is 1 exactly when the slot was sampled with both `inValid` and `inDummy` high. This marks `outMetric` and `outDecision` as don't-care for that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | A state enters this cycle |
| inDummy | input | 1 | The entering state is a pipeline filler |
| inTag | input | TW | State identifier carried to the output |
| halfOff | input | 2 | Bit 0 suppresses candidates 0,1; bit 1 suppresses candidates 2,3 |
| pathIn | input | 4*MW | Four predecessor path metrics, candidate k at bits k*MW |
| branchIn | input | 4*BW | Four branch metrics, candidate k at bits k*BW |
| outValid | output | 1 | Result slot holds a state |
| outDummy | output | 1 | Result slot is a filler; metric and decision are don't-care |
| outTag | output | TW | Tag of the result slot |
| outMetric | output | MW | Surviving path metric |
| outDecision | output | 2 | Index of the winning candidate |

## Verification
The assertions check on every cycle that the valid, filler and tag bits arrive exactly three cycles after they entered. They also check that the surviving metric is never larger than any candidate registered in stage one, and that a suppressed candidate wins only when the result is the saturated maximum. Only the bench's scenarios can show the lowest-index rule for ties, which cover ties inside one pair and across the two pairs. The same holds for the saturation value, for the result with both halves suppressed, and for the loss of in-flight results when reset strikes in the middle of a stream. The bench compares every slot against a reference that scans the candidates one by one. This reference is computed from the requirements under random masks and random values.

// File: rtl/acs4_pkg.sv
package acs4_pkg;
  localparam int NCAND = 4;
  localparam int IDXW  = 2;
  localparam int LAT   = 3;

  typedef struct packed {
    logic [NCAND-1:0] kill;   // per-candidate suppression for the entering state
    logic             warm;   // at least LAT edges since reset release
  } acsStrobe_t;
endpackage

// File: rtl/acs4_cmpsel.sv
module acs4_cmpsel #(
  parameter int MW = 10,
  parameter int IW = 2
) (
  input  logic [MW-1:0] aMet,
  input  logic [IW-1:0] aIdx,
  input  logic [MW-1:0] bMet,
  input  logic [IW-1:0] bIdx,
  output logic [MW-1:0] winMet,
  output logic [IW-1:0] winIdx
);
  logic takeB;

  // side b is always the higher index, so it wins only when strictly smaller
  assign takeB  = bMet < aMet;
  assign winMet = takeB ? bMet : aMet;
  assign winIdx = takeB ? bIdx : aIdx;
endmodule

// File: rtl/acs4_ctrl.sv
module acs4_ctrl
  import acs4_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          inDummy,
  input  logic [TW-1:0] inTag,
  input  logic [1:0]    halfOff,
  output acsStrobe_t    st,
  output logic          outValid,
  output logic          outDummy,
  output logic [TW-1:0] outTag
);
  localparam int AGEW = $clog2(LAT + 1);

  logic          vPipe [LAT];
  logic          dPipe [LAT];
  logic [TW-1:0] tPipe [LAT];
  logic [AGEW-1:0] ageCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ageCnt <= '0;
    else if (ageCnt != AGEW'(LAT)) ageCnt <= ageCnt + 1'b1;
  end

  always_comb begin
    st.kill = {halfOff[1], halfOff[1], halfOff[0], halfOff[0]};
    st.warm = (ageCnt == AGEW'(LAT));
  end

  generate
    for (genvar s = 0; s < LAT; s++) begin : gStage
      if (s == 0) begin : gHead
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            vPipe[0] <= 1'b0;
            dPipe[0] <= 1'b0;
            tPipe[0] <= '0;
          end else begin
            vPipe[0] <= inValid;
            dPipe[0] <= inValid & inDummy;
            tPipe[0] <= inTag;
          end
        end
      end else begin : gBody
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            vPipe[s] <= 1'b0;
            dPipe[s] <= 1'b0;
            tPipe[s] <= '0;
          end else begin
            vPipe[s] <= vPipe[s-1];
            dPipe[s] <= dPipe[s-1];
            tPipe[s] <= tPipe[s-1];
          end
        end
      end
    end
  endgenerate

  assign outValid = vPipe[LAT-1];
  assign outDummy = dPipe[LAT-1];
  assign outTag   = tPipe[LAT-1];

  // R2: valid emerges exactly three cycles after entry
  a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rstN)
    st.warm |-> (outValid == $past(inValid, 3)));

  // R6: tag follows its slot
  a_r6_tag_follow: assert property (@(posedge clk) disable iff (!rstN)
    (st.warm && outValid) |-> (outTag == $past(inTag, 3)));

  // R7: filler mark follows its slot and only on valid slots
  a_r7_dummy_latency: assert property (@(posedge clk) disable iff (!rstN)
    st.warm |-> (outDummy == $past(inValid && inDummy, 3)));

  // R1: nothing valid on the first edge after reset release
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    (ageCnt == '0) |-> (!outValid && !outDummy));
endmodule

// File: rtl/acs4_dpath.sv
module acs4_dpath
  import acs4_pkg::*;
#(
  parameter int MW = 10,
  parameter int BW = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  acsStrobe_t          st,
  input  logic [NCAND*MW-1:0] pathIn,
  input  logic [NCAND*BW-1:0] branchIn,
  output logic [MW-1:0]       outMetric,
  output logic [IDXW-1:0]     outDecision
);
  localparam int SW = MW + 1;
  localparam int NPAIR = NCAND / 2;
  localparam logic [MW-1:0] MAXM = '1;

  logic [MW-1:0]   cand   [NCAND];
  logic [MW-1:0]   l1WinM [NPAIR];
  logic [IDXW-1:0] l1WinI [NPAIR];
  logic [MW-1:0]   l1M    [NPAIR];
  logic [IDXW-1:0] l1I    [NPAIR];
  logic [MW-1:0]   finM;
  logic [IDXW-1:0] finI;

  // stage 1: add, saturate, suppress
  generate
    for (genvar k = 0; k < NCAND; k++) begin : gAdd
      logic [SW-1:0] sumK;
      logic [MW-1:0] nextK;
      always_comb begin
        sumK  = {1'b0, pathIn[k*MW +: MW]} + SW'(branchIn[k*BW +: BW]);
        nextK = sumK[MW] ? MAXM : sumK[MW-1:0];
        if (st.kill[k]) nextK = MAXM;
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) cand[k] <= MAXM;
        else       cand[k] <= nextK;
      end
    end
  endgenerate

  // stage 2: pairwise compare-select
  generate
    for (genvar g = 0; g < NPAIR; g++) begin : gLvl1
      acs4_cmpsel #(.MW(MW), .IW(IDXW)) uCs (
        .aMet  (cand[2*g]),
        .aIdx  (IDXW'(2*g)),
        .bMet  (cand[2*g+1]),
        .bIdx  (IDXW'(2*g+1)),
        .winMet(l1WinM[g]),
        .winIdx(l1WinI[g])
      );
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          l1M[g] <= MAXM;
          l1I[g] <= '0;
        end else begin
          l1M[g] <= l1WinM[g];
          l1I[g] <= l1WinI[g];
        end
      end
    end
  endgenerate

  // stage 3: final compare-select
  acs4_cmpsel #(.MW(MW), .IW(IDXW)) uFinal (
    .aMet  (l1M[0]),
    .aIdx  (l1I[0]),
    .bMet  (l1M[1]),
    .bIdx  (l1I[1]),
    .winMet(finM),
    .winIdx(finI)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outMetric   <= MAXM;
      outDecision <= '0;
    end else begin
      outMetric   <= finM;
      outDecision <= finI;
    end
  end

  // R3: the survivor never exceeds any candidate registered two cycles earlier
  generate
    for (genvar k = 0; k < NCAND; k++) begin : gMinChk
      a_r3_min_bound: assert property (@(posedge clk) disable iff (!rstN)
        st.warm |-> (outMetric <= $past(cand[k], 2)));
    end
  endgenerate

  // R5: a suppressed candidate only wins when the result is saturated
  a_r5_killed_loses: assert property (@(posedge clk) disable iff (!rstN)
    (st.warm && outMetric != MAXM) |->
      ((($past(st.kill, 3) >> outDecision) & 4'd1) == 4'd0));
endmodule

// File: rtl/acs4_pipe.sv
module acs4_pipe
  import acs4_pkg::*;
#(
  parameter int MW = 10,
  parameter int BW = 6,
  parameter int TW = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic                inDummy,
  input  logic [TW-1:0]       inTag,
  input  logic [1:0]          halfOff,
  input  logic [NCAND*MW-1:0] pathIn,
  input  logic [NCAND*BW-1:0] branchIn,
  output logic                outValid,
  output logic                outDummy,
  output logic [TW-1:0]       outTag,
  output logic [MW-1:0]       outMetric,
  output logic [IDXW-1:0]     outDecision
);
  acsStrobe_t st;

  acs4_ctrl #(.TW(TW)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inDummy (inDummy),
    .inTag   (inTag),
    .halfOff (halfOff),
    .st      (st),
    .outValid(outValid),
    .outDummy(outDummy),
    .outTag  (outTag)
  );

  acs4_dpath #(.MW(MW), .BW(BW)) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .pathIn     (pathIn),
    .branchIn   (branchIn),
    .outMetric  (outMetric),
    .outDecision(outDecision)
  );
endmodule

// File: tb/acs4_pipe_test.sv
module acs4_pipe_test;
  localparam int MW = 10;
  localparam int BW = 6;
  localparam int TW = 4;
  localparam int MAXV = (1 << MW) - 1;
  localparam int NT = 11;
  localparam int NV = NT + 150;

  // directed table: path metrics, branch metrics, mask, expected metric, expected decision
  localparam int TP [NT][4] = '{
    '{100, 200, 300, 400}, '{400, 300, 200, 100}, '{50, 50, 50, 50},
    '{90, 80, 80, 90},     '{10, 20, 500, 500},   '{900, 900, 5, 6},
    '{1, 2, 3, 4},         '{1023, 1020, 1000, 1010}, '{300, 299, 301, 302},
    '{70, 80, 70, 90},     '{60, 55, 54, 54}};
  localparam int TB [NT][4] = '{
    '{5, 5, 5, 5}, '{0, 0, 0, 0}, '{7, 7, 7, 7}, '{0, 0, 0, 0},
    '{0, 0, 0, 0}, '{0, 0, 0, 0}, '{0, 0, 0, 0}, '{63, 63, 63, 10},
    '{0, 2, 0, 0}, '{0, 0, 0, 0}, '{0, 0, 0, 0}};
  localparam int TM [NT] = '{0, 0, 0, 0, 1, 2, 3, 0, 0, 0, 0};
  localparam int TEM [NT] = '{105, 100, 57, 80, 500, 900, 1023, 1020, 300, 70, 54};
  localparam int TED [NT] = '{0, 3, 0, 1, 2, 0, 0, 3, 0, 0, 2};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inDummy = 1'b0;
  logic [TW-1:0] inTag = '0;
  logic [1:0] halfOff = '0;
  logic [4*MW-1:0] pathIn = '0;
  logic [4*BW-1:0] branchIn = '0;
  logic outValid, outDummy;
  logic [TW-1:0] outTag;
  logic [MW-1:0] outMetric;
  logic [1:0] outDecision;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  int sP [NV][4];
  int sB [NV][4];
  int sM [NV];
  int sV [NV];
  int sD [NV];
  int eM [NV];
  int eD [NV];

  always #5 clk = ~clk;

  acs4_pipe #(.MW(MW), .BW(BW), .TW(TW)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inDummy(inDummy), .inTag(inTag),
    .halfOff(halfOff), .pathIn(pathIn), .branchIn(branchIn), .outValid(outValid),
    .outDummy(outDummy), .outTag(outTag), .outMetric(outMetric), .outDecision(outDecision)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference from the requirements: linear scan, lowest index kept on ties
  task automatic refAcs(input int n);
    int best;
    int bi;
    best = 0;
    bi = 0;
    for (int k = 0; k < 4; k++) begin
      int c;
      c = sP[n][k] + sB[n][k];
      if (c > MAXV) c = MAXV;
      if ((k < 2 && sM[n][0]) || (k >= 2 && sM[n][1])) c = MAXV;
      if (k == 0 || c < best) begin
        best = c;
        bi = k;
      end
    end
    eM[n] = best;
    eD[n] = bi;
  endtask

  task automatic driveSlot(input int n);
    inValid = sV[n][0];
    inDummy = sD[n][0];
    inTag = TW'(n);
    halfOff = sM[n][1:0];
    for (int k = 0; k < 4; k++) begin
      pathIn[k*MW +: MW] = sP[n][k][MW-1:0];
      branchIn[k*BW +: BW] = sB[n][k][BW-1:0];
    end
  endtask

  task automatic driveIdle();
    inValid = 1'b0;
    inDummy = 1'b0;
    halfOff = '0;
  endtask

  task automatic checkSlot(input int n);
    chk("R2", "outValid", int'(outValid), sV[n]);
    chk("R7", "outDummy", int'(outDummy), (sV[n] != 0 && sD[n] != 0) ? 1 : 0);
    if (sV[n] != 0) chk("R6", "outTag", int'(outTag), n % (1 << TW));
    if (sV[n] != 0 && sD[n] == 0) begin
      chk((sM[n] != 0) ? "R5" : "R3", "outMetric", int'(outMetric), eM[n]);
      chk((sM[n] != 0) ? "R5" : "R4", "outDecision", int'(outDecision), eD[n]);
    end
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      checks++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    // build the stimulus stream
    for (int n = 0; n < NV; n++) begin
      if (n < NT) begin
        for (int k = 0; k < 4; k++) begin
          sP[n][k] = TP[n][k];
          sB[n][k] = TB[n][k];
        end
        sM[n] = TM[n];
        sV[n] = 1;
        sD[n] = 0;
        eM[n] = TEM[n];
        eD[n] = TED[n];
      end else begin
        for (int k = 0; k < 4; k++) begin
          sP[n][k] = (n % 3 == 0) ? int'($urandom_range(0, 7)) : int'($urandom_range(0, MAXV));
          sB[n][k] = (n % 3 == 0) ? int'($urandom_range(0, 3)) : int'($urandom_range(0, 63));
        end
        sM[n] = ($urandom_range(0, 1) == 1) ? int'($urandom_range(0, 3)) : 0;
        sV[n] = ($urandom_range(0, 3) != 0) ? 1 : 0;
        sD[n] = ($urandom_range(0, 7) == 0 || n == NT + 9) ? 1 : 0;
        if (n == NT + 9) sV[n] = 1;
        refAcs(n);
      end
    end

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "outValid in reset", int'(outValid), 0);
    chk("R1", "outDummy in reset", int'(outDummy), 0);
    rstN = 1'b1;

    // table then random stream, compared three cycles later (R2..R7)
    for (int n = 0; n < NV + 3; n++) begin
      @(negedge clk);
      if (n >= 3) checkSlot(n - 3);
      else chk("R2", "outValid before first result", int'(outValid), 0);
      if (n < NV) driveSlot(n);
      else driveIdle();
    end

    // R1: reset in the middle of a full pipeline discards in-flight results
    for (int n = 0; n < 2; n++) begin
      @(negedge clk);
      driveSlot(n);
    end
    @(negedge clk);
    driveIdle();
    rstN = 1'b0;
    #1;
    chk("R1", "outValid during mid reset", int'(outValid), 0);
    @(negedge clk);
    rstN = 1'b1;
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      chk("R1", "outValid after mid reset", int'(outValid), 0);
      chk("R1", "outDummy after mid reset", int'(outDummy), 0);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule